// File: doc/BRIEF.md
# Module Clock Enable Controller

This block is the clock gating controller for one peripheral module. Software reaches it through a single 32-bit control/status word. The word holds a two-bit mode field that requests the module's state, a status field that reports the state the module has acknowledged, and an optional enable bit for a secondary debounce clock. The block does not drive the clock gate cell itself. It drives an enable that the gate cell samples. It also handshakes with the module, using a wake acknowledge when the clock starts and an idle request/acknowledge pair before the clock stops.

The mode field only states a request. The status field lags behind it. After requesting enable, software reads the word until the status reads functional (0), and only then uses the module. A disable request first asks the module to go idle. The gate closes only after the module agrees. Status then passes through idle (2) to disabled (3). Mode values other than enable are stored as written but act as disable.

Top module: `modclk_gate_ctrl`

## Requirements
- R1: After reset the word reads 0x0003_0000, meaning mode 0, status 3 (disabled) and debounce bit 0. The clock enable, idle request and debounce clock enable outputs are all low.
- R2: The mode field in bits [1:0] and the debounce bit in bit 18 read back exactly what was last written. Bits [17:16] read the status. Every other bit reads 0, whatever was written to it.
- R3: A write of mode 2 while the status is 3 raises the clock enable in the cycle after the write edge and sets the status to 1 (transitioning).
- R4: While waking, the status stays at 1 until the wake acknowledge input is high at a clock edge. From the following cycle it reads 0 (functional).
- R5: A write of a mode other than 2 while the status is 0 or 1 (waking) raises the idle request and holds the status at 1. The clock enable stays high until the idle acknowledge input is high at a clock edge.
- R6: After the idle acknowledge, the status reads 2 for exactly one cycle, and in that cycle the clock enable and idle request are low. The status then reads 3.
- R7: Mode values 1 and 3 are stored and read back, but they act exactly like mode 0.
- R8: The debounce clock enable output equals bit 18 ANDed with the clock enable output.
- R9: A write of mode 2 made while the disable handshake is pending does not cut that handshake short. After the status has read 2 and then 3, the block wakes again: status 1 with the clock enabled.
- R10: If a disable write and the wake acknowledge arrive at the same edge, the disable wins. The status goes to 1 with the idle request high, and not to 0.
- R11: An acknowledge input has no effect outside the state that waits for it. Wake acknowledge with status 3 and idle acknowledge with status 0 or 1 (waking) leave the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | 32 | Write data: mode [1:0], debounce enable [18] |
| rdData | output | 32 | Read data: mode [1:0], status [17:16], debounce enable [18] |
| modClkEn | output | 1 | Functional clock gate enable |
| modDbClkEn | output | 1 | Debounce clock gate enable |
| modIdleReq | output | 1 | Request to the module to go idle |
| modWakeAck | input | 1 | Module reports it is functional |
| modIdleAck | input | 1 | Module reports it is idle |

## Verification
A wrong state register shows at the ports within one cycle. The status bits in the read word and the gate enable come straight from the state, so an illegal jump appears as a status sequence the requirements forbid, for example 0 to 3 without passing through 1 and 2. A lost or extra acknowledge appears as a status that never settles or settles too early, and this is visible at the first polled read. A wrong field store appears at the very next read of the word.

// File: rtl/modclk_pkg.sv
package modclk_pkg;

  // Field positions are fixed: software decodes them.
  localparam int MODE_LSB  = 0;
  localparam int STAT_LSB  = 16;
  localparam int DB_BIT    = 18;
  localparam int MODE_W    = 2;
  localparam int STAT_W    = 2;

  localparam logic [MODE_W-1:0] MODE_ENABLE = 2'd2;

  // Reported status codes
  localparam logic [STAT_W-1:0] STAT_FUNC  = 2'd0;
  localparam logic [STAT_W-1:0] STAT_TRANS = 2'd1;
  localparam logic [STAT_W-1:0] STAT_IDLE  = 2'd2;
  localparam logic [STAT_W-1:0] STAT_OFF   = 2'd3;

  typedef enum logic [2:0] {
    GS_OFF,
    GS_WAKE,
    GS_RUN,
    GS_STOP,
    GS_IDLE
  } gateState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic              clkOn;
    logic              idleReq;
    logic [STAT_W-1:0] status;
  } gateCtrl_t;

endpackage

// File: rtl/modclk_fsm.sv
module modclk_fsm
  import modclk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      enReq,
  input  logic      wakeAck,
  input  logic      idleAck,
  output gateCtrl_t ctrl
);

  gateState_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      GS_OFF:  if (enReq) stateD = GS_WAKE;
      GS_WAKE: begin
        if (!enReq)       stateD = GS_STOP;   // disable beats a late ack
        else if (wakeAck) stateD = GS_RUN;
      end
      GS_RUN:  if (!enReq) stateD = GS_STOP;
      GS_STOP: if (idleAck) stateD = GS_IDLE; // handshake always completes
      GS_IDLE: stateD = GS_OFF;
      default: stateD = GS_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= GS_OFF;
    else       stateQ <= stateD;
  end

  always_comb begin
    ctrl = '{clkOn: 1'b0, idleReq: 1'b0, status: STAT_OFF};
    unique case (stateQ)
      GS_OFF:  ctrl = '{clkOn: 1'b0, idleReq: 1'b0, status: STAT_OFF};
      GS_WAKE: ctrl = '{clkOn: 1'b1, idleReq: 1'b0, status: STAT_TRANS};
      GS_RUN:  ctrl = '{clkOn: 1'b1, idleReq: 1'b0, status: STAT_FUNC};
      GS_STOP: ctrl = '{clkOn: 1'b1, idleReq: 1'b1, status: STAT_TRANS};
      GS_IDLE: ctrl = '{clkOn: 1'b0, idleReq: 1'b0, status: STAT_IDLE};
      default: ctrl = '{clkOn: 1'b0, idleReq: 1'b0, status: STAT_OFF};
    endcase
  end

endmodule

// File: rtl/modclk_regs.sv
module modclk_regs
  import modclk_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter bit HAS_DBCLK = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  gateCtrl_t        ctrl,
  output logic             enReq,
  output logic [REG_W-1:0] rdData,
  output logic             modClkEn,
  output logic             modDbClkEn,
  output logic             modIdleReq
);

  logic [MODE_W-1:0] modeQ;
  logic [MODE_W-1:0] modeNext;
  logic              dbQ;

  // Reserved write bits are discarded.
  logic unusedWrBits;
  assign unusedWrBits = ^{wrData[REG_W-1:DB_BIT+1], wrData[STAT_LSB+STAT_W-1:MODE_LSB+MODE_W]};

  assign modeNext = wrEn ? wrData[MODE_LSB +: MODE_W] : modeQ;
  assign enReq    = (modeNext == MODE_ENABLE);

  always_ff @(posedge clk) begin
    if (!rstN)     modeQ <= '0;
    else if (wrEn) modeQ <= wrData[MODE_LSB +: MODE_W];
  end

  generate
    if (HAS_DBCLK) begin : g_db
      always_ff @(posedge clk) begin
        if (!rstN)     dbQ <= 1'b0;
        else if (wrEn) dbQ <= wrData[DB_BIT];
      end
    end else begin : g_nodb
      logic unusedDb;
      assign unusedDb = wrData[DB_BIT];
      assign dbQ      = 1'b0;
    end
  endgenerate

  always_comb begin
    rdData                        = '0;
    rdData[MODE_LSB +: MODE_W]    = modeQ;
    rdData[STAT_LSB +: STAT_W]    = ctrl.status;
    rdData[DB_BIT]                = dbQ;
  end

  assign modClkEn   = ctrl.clkOn;
  assign modIdleReq = ctrl.idleReq;
  assign modDbClkEn = dbQ & ctrl.clkOn;

endmodule

// File: rtl/modclk_gate_ctrl.sv
module modclk_gate_ctrl
  import modclk_pkg::*;
#(
  parameter int REG_W     = 32,
  parameter bit HAS_DBCLK = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             modClkEn,
  output logic             modDbClkEn,
  output logic             modIdleReq,
  input  logic             modWakeAck,
  input  logic             modIdleAck
);

  gateCtrl_t ctrl;
  logic      enReq;

  modclk_fsm u_fsm (
    .clk     (clk),
    .rstN    (rstN),
    .enReq   (enReq),
    .wakeAck (modWakeAck),
    .idleAck (modIdleAck),
    .ctrl    (ctrl)
  );

  modclk_regs #(.REG_W(REG_W), .HAS_DBCLK(HAS_DBCLK)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .ctrl       (ctrl),
    .enReq      (enReq),
    .rdData     (rdData),
    .modClkEn   (modClkEn),
    .modDbClkEn (modDbClkEn),
    .modIdleReq (modIdleReq)
  );

endmodule

// File: rtl/modclk_gate_ctrl_chk.sv
module modclk_gate_ctrl_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] wrMode,
  input logic [1:0] status,
  input logic       modClkEn,
  input logic       modDbClkEn,
  input logic       modIdleReq,
  input logic       modWakeAck,
  input logic       modIdleAck
);

  assert_enable_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrMode == 2'd2 && status == 2'd3) |=> (modClkEn && status == 2'd1));

  assert_func_after_ack_R4: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd0 && $past(status) != 2'd0) |-> ($past(status) == 2'd1 && $past(modWakeAck)));

  assert_idle_req_clock_on_R5: assert property (@(posedge clk) disable iff (!rstN)
    modIdleReq |-> (modClkEn && status == 2'd1));

  assert_idle_after_ack_R6: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd2) |-> (!modClkEn && !modIdleReq && $past(status) == 2'd1 && $past(modIdleAck)));

  assert_off_via_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd3 && $past(status) != 2'd3) |-> ($past(status) == 2'd2));

  assert_reserved_disables_R7: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd0 && wrEn && wrMode != 2'd2) |=> modIdleReq);

  assert_db_follows_clk_R8: assert property (@(posedge clk) disable iff (!rstN)
    modDbClkEn |-> modClkEn);

  assert_run_holds_R11: assert property (@(posedge clk) disable iff (!rstN)
    (status == 2'd0 && !(wrEn && wrMode != 2'd2)) |=> (status == 2'd0));

endmodule

bind modclk_gate_ctrl modclk_gate_ctrl_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrMode     (wrData[1:0]),
  .status     (rdData[17:16]),
  .modClkEn   (modClkEn),
  .modDbClkEn (modDbClkEn),
  .modIdleReq (modIdleReq),
  .modWakeAck (modWakeAck),
  .modIdleAck (modIdleAck)
);

// File: tb/sim_modclk_gate_ctrl.sv
module sim_modclk_gate_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [31:0] wrData;
  logic [31:0] rdData;
  logic        modClkEn, modDbClkEn, modIdleReq;
  logic        modWakeAck, modIdleAck;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modclk_gate_ctrl u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .modClkEn(modClkEn), .modDbClkEn(modDbClkEn), .modIdleReq(modIdleReq),
    .modWakeAck(modWakeAck), .modIdleAck(modIdleAck)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    wrEn = 1'b1; wrData = d;
    cyc();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pulseWake();
    modWakeAck = 1'b1; cyc(); modWakeAck = 1'b0;
  endtask

  task automatic pulseIdle();
    modIdleAck = 1'b1; cyc(); modIdleAck = 1'b0;
  endtask

  function automatic logic [31:0] word(input logic db, input logic [1:0] st, input logic [1:0] m);
    return {13'd0, db, st, 14'd0, m};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; wrEn = 1'b0; wrData = '0; modWakeAck = 1'b0; modIdleAck = 1'b0;
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    chk("R1 reset word", rdData, 32'h0003_0000);
    chk("R1 reset outputs", {29'd0, modClkEn, modIdleReq, modDbClkEn}, 32'd0);

    // R2/R7/R8 sweep over non-enable modes and debounce bit from disabled
    for (int m = 0; m < 4; m++) begin
      for (int db = 0; db < 2; db++) begin
        if (m == 2) continue;
        wr(32'hFFFB_FFFC | 32'(m) | (32'(db) << 18));
        chk("R2 readback", rdData, word(db[0], 2'd3, m[1:0]));
        chk("R7 stays off", {31'd0, modClkEn}, 32'd0);
        chk("R8 db gated off", {31'd0, modDbClkEn}, 32'd0);
      end
    end

    // R11 wake ack ignored while off
    pulseWake();
    chk("R11 wake ack when off", rdData, word(1'b1, 2'd3, 2'd3));

    // R3 enable with debounce
    wr(32'h0004_0002);
    chk("R3 status trans", rdData, word(1'b1, 2'd1, 2'd2));
    chk("R3 clock on", {31'd0, modClkEn}, 32'd1);
    chk("R8 db on", {31'd0, modDbClkEn}, 32'd1);
    repeat (3) cyc();
    chk("R4 waits for ack", {30'd0, rdData[17:16]}, 32'd1);
    pulseIdle();
    chk("R11 idle ack while waking", {30'd0, rdData[17:16]}, 32'd1);
    pulseWake();
    chk("R4 functional", {30'd0, rdData[17:16]}, 32'd0);
    pulseIdle();
    chk("R11 idle ack while running", {30'd0, rdData[17:16]}, 32'd0);
    chk("R11 clock still on", {31'd0, modClkEn}, 32'd1);

    // R5/R6 disable
    wr(32'h0000_0000);
    chk("R5 stop word", rdData, word(1'b0, 2'd1, 2'd0));
    chk("R5 idle req and clock", {30'd0, modIdleReq, modClkEn}, 32'd3);
    chk("R8 db off when bit clear", {31'd0, modDbClkEn}, 32'd0);
    repeat (2) cyc();
    chk("R5 waits for idle ack", {30'd0, modIdleReq, modClkEn}, 32'd3);
    pulseIdle();
    chk("R6 idle status", {30'd0, rdData[17:16]}, 32'd2);
    chk("R6 gate closed", {30'd0, modIdleReq, modClkEn}, 32'd0);
    cyc();
    chk("R6 disabled status", {30'd0, rdData[17:16]}, 32'd3);

    // R7 reserved modes act as disable from running
    for (int k = 0; k < 2; k++) begin
      logic [1:0] m;
      m = (k == 0) ? 2'd1 : 2'd3;
      wr(32'h0000_0002);
      pulseWake();
      chk("R4 run before reserved", {30'd0, rdData[17:16]}, 32'd0);
      wr({30'd0, m});
      chk("R7 reserved stops", rdData, word(1'b0, 2'd1, m));
      chk("R7 idle req", {31'd0, modIdleReq}, 32'd1);
      pulseIdle();
      cyc();
      chk("R7 reserved ends off", rdData, word(1'b0, 2'd3, m));
    end

    // R10 disable beats simultaneous wake ack
    wr(32'h0000_0002);
    modWakeAck = 1'b1;
    wr(32'h0000_0000);
    modWakeAck = 1'b0;
    chk("R10 disable wins", {29'd0, rdData[17:16], modIdleReq}, 32'd3);
    pulseIdle();
    cyc();
    chk("R10 ends off", {30'd0, rdData[17:16]}, 32'd3);

    // R9 enable during pending stop
    wr(32'h0000_0002);
    pulseWake();
    wr(32'h0000_0000);
    wr(32'h0000_0002);
    chk("R9 stop continues", {29'd0, rdData[17:16], modIdleReq}, 32'd3);
    pulseIdle();
    chk("R9 idle", {30'd0, rdData[17:16]}, 32'd2);
    cyc();
    chk("R9 off", {30'd0, rdData[17:16]}, 32'd3);
    cyc();
    chk("R9 rewake", {29'd0, rdData[17:16], modClkEn}, 32'd3);
    pulseWake();
    chk("R9 functional", rdData, word(1'b0, 2'd0, 2'd2));

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule